// File: doc/BRIEF.md
# Bisync Transmit Framer

The framer sits between a transmit byte FIFO and a parallel-to-serial shifter on a character-synchronous line. When the line is quiet it keeps sending an idle character: either SYN or the all-ones mark character. Once the FIFO presents a byte, it opens a frame. In mark idle mode it first sends a configured number of leading pad characters. It then sends two SYN characters, followed by the FIFO bytes. At the end it sends the block check character(s) when the frame calls for them, then a trailing pad, and then returns to idle. The shifter takes one character from `tx_char` in each cycle where `ser_ready` is high.

The framer works out the frame type from the bytes it passes through. A leading SOH or STX opens a checked frame. A leading DLE STX opens a transparent checked frame. Any other opening gives an unchecked control sequence. Some bytes are left out of the block check: SYN fill, the opening SOH/STX, and DLE prefixes in transparent text. The block check is either a CRC-16 or an 8-bit longitudinal XOR. An abort strobe replaces the rest of the frame with EOT and the trailing pad.

The state machine has these states: `ST_IDLE`, `ST_LEAD_PAD`, `ST_SYN_A`, `ST_SYN_B`, `ST_DATA`, `ST_BCC_LO`, `ST_BCC_HI`, `ST_ABORT_EOT`, `ST_TRAIL_PAD`. The transitions are:
- IDLE→LEAD_PAD when a character is taken with FIFO data present and pads are enabled.
- IDLE→SYN_A on the same condition when pads are not enabled.
- LEAD_PAD→SYN_A after the last pad.
- SYN_A→SYN_B, then SYN_B→DATA.
- DATA→BCC_LO when the end-of-frame byte leaves a check pending.
- DATA→TRAIL_PAD on an EOT/ENQ ending or on an unchecked frame.
- BCC_LO→BCC_HI for CRC, or BCC_LO→TRAIL_PAD for LRC.
- BCC_HI→TRAIL_PAD.
- Any state from LEAD_PAD through BCC_HI goes to ABORT_EOT on abort when the shifter is not ready, or straight to TRAIL_PAD on abort when it is ready.
- ABORT_EOT→TRAIL_PAD, then TRAIL_PAD→IDLE.

Every state other than ABORT_EOT, and every state other than IDLE, advances only when a character is taken.

Top module: `bsc_tx_framer`

## Requirements
- R1: While idle, `tx_active` is 0 and `tx_char` is the SYN code when `cfg_idle_mark`=0, or 0xFF when `cfg_idle_mark`=1; after reset the block is idle.
- R2: A frame starts when a character is taken in idle with `fifo_valid`=1. It sends `cfg_pad_count` pads only when `cfg_idle_mark`=1. The pad value is 0xAA when `cfg_pad_zero`=0 and 0x00 when it is 1. Two SYN characters follow, then the FIFO bytes in order.
- R3: `fifo_rd` is high only in a cycle where a FIFO byte is sent as `tx_char`, with `ser_ready`=1, `fifo_valid`=1 and no abort; it is never high during pads, SYN, check or trailing characters.
- R4: If the FIFO runs empty inside the data phase, SYN is sent for each character taken, and these fills are left out of the block check.
- R5: Non-transparent frame: the first byte SOH (0x01) or STX (0x02) enables the check and is itself excluded. After that, SYN bytes are excluded and all other bytes are included, including a closing ETX or ETB.
- R6: A frame that opens with DLE then STX is transparent; both are excluded. In the text, a DLE not itself prefixed is excluded. The byte after such a DLE is excluded if it is SYN, and included otherwise, so DLE DLE counts one DLE and DLE ETX counts ETX. Bytes without a prefix are included, SYN among them.
- R7: With `cfg_lrc`=0 the check is CRC-16 (x^16+x^15+x^2+1, bit-reflected, zero start), sent low byte then high byte. With `cfg_lrc`=1 it is one byte, the XOR of the included bytes.
- R8: The frame ends with the byte flagged by `fifo_eof`. If that byte is EOT or ENQ (in transparent text only when DLE-prefixed), or the frame never enabled the check, only the trailing pad 0xFF follows. Otherwise the check is sent, then 0xFF. The block is then idle again.
- R9: `abort_req` in any frame state from pad through check makes the next character taken EOT, followed by 0xFF and idle, and no FIFO byte is read in that cycle. It has no effect in idle, the abort EOT state or the trailing pad state.
- R10: `cfg_ebcdic` selects the code set: SYN 0x16/0x32, EOT 0x04/0x37, ENQ 0x05/0x2D, ETB 0x17/0x26 (ASCII/EBCDIC). SOH 0x01, STX 0x02, ETX 0x03 and DLE 0x10 are the same in both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle_mark | input | 1 | 1: idle in mark (0xFF), 0: idle in SYN |
| cfg_pad_count | input | PAD_CNT_W | Leading pads per frame in mark idle mode |
| cfg_pad_zero | input | 1 | Leading pad value: 1 gives 0x00, 0 gives 0xAA |
| cfg_ebcdic | input | 1 | Control code set: 1 EBCDIC, 0 ASCII |
| cfg_lrc | input | 1 | Block check: 1 LRC, 0 CRC-16 |
| fifo_valid | input | 1 | FIFO head byte present |
| fifo_data | input | 8 | FIFO head byte |
| fifo_eof | input | 1 | FIFO head byte is the last of its frame |
| fifo_rd | output | 1 | Pop the FIFO head byte |
| abort_req | input | 1 | Abort the current frame |
| ser_ready | input | 1 | Shifter takes `tx_char` this cycle |
| tx_char | output | 8 | Character offered to the shifter |
| tx_active | output | 1 | A frame is in progress (not idle) |

## Verification
Two conditions are hard to reach from the ports. The first is a FIFO underrun in the middle of the data phase. The second is an abort landing on one exact character, such as a pad, the first SYN or the low check byte. The bench reaches an underrun by holding `fifo_valid` low for a set number of taken characters at a chosen byte index. It reaches the abort case by raising `abort_req` when its own count of characters taken equals a chosen position, with `ser_ready` either high or low in that cycle. Transparent text is built with doubled DLEs and DLE SYN fills so that the inclusion rules are exercised at random positions.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
package bsc_pkg;

    localparam int BSC_CHAR_W = 8;
    localparam int BSC_CRC_W  = 16;

    localparam logic [BSC_CHAR_W-1:0] MARK_CHAR  = 8'hFF;
    localparam logic [BSC_CHAR_W-1:0] TRAIL_CHAR = 8'hFF;
    localparam logic [BSC_CHAR_W-1:0] PAD_TOGGLE = 8'hAA;
    localparam logic [BSC_CHAR_W-1:0] PAD_FLAT   = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD_PAD,
        ST_SYN_A,
        ST_SYN_B,
        ST_DATA,
        ST_BCC_LO,
        ST_BCC_HI,
        ST_ABORT_EOT,
        ST_TRAIL_PAD
    } tx_state_e;

    typedef enum logic [2:0] {
        C_SYN, C_EOT, C_ENQ, C_STX, C_SOH, C_ETX, C_ETB, C_DLE
    } ctl_e;

    function automatic logic [BSC_CHAR_W-1:0] ctl_code(ctl_e c, logic ebcdic);
        logic [BSC_CHAR_W-1:0] v;
        unique case (c)
            C_SYN:   v = ebcdic ? 8'h32 : 8'h16;
            C_EOT:   v = ebcdic ? 8'h37 : 8'h04;
            C_ENQ:   v = ebcdic ? 8'h2D : 8'h05;
            C_ETB:   v = ebcdic ? 8'h26 : 8'h17;
            C_STX:   v = 8'h02;
            C_SOH:   v = 8'h01;
            C_ETX:   v = 8'h03;
            C_DLE:   v = 8'h10;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bsc_bcc_unit.sv
`timescale 1ns/1ps
module bsc_bcc_unit
    import bsc_pkg::*;
#(
    parameter int                 CHAR_W    = BSC_CHAR_W,
    parameter int                 CRC_W     = BSC_CRC_W,
    parameter logic [CRC_W-1:0]   POLY_REFL = 16'hA001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [CHAR_W-1:0] din,
    output logic [CRC_W-1:0]  crc_q,
    output logic [CHAR_W-1:0] lrc_q
);

    logic [CRC_W-1:0] stage [0:CHAR_W];

    assign stage[0] = crc_q ^ {{(CRC_W-CHAR_W){1'b0}}, din};

    for (genvar g = 0; g < CHAR_W; g++) begin : g_crc_bit
        assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY_REFL)
                                        : (stage[g] >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
            lrc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
            lrc_q <= '0;
        end else if (en) begin
            crc_q <= stage[CHAR_W];
            lrc_q <= lrc_q ^ din;
        end
    end

endmodule

// File: rtl/bsc_frame_tracker.sv
`timescale 1ns/1ps
module bsc_frame_tracker
    import bsc_pkg::*;
#(
    parameter int CHAR_W = BSC_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              accept,
    input  logic [CHAR_W-1:0] din,
    input  logic              ebcdic,
    output logic              byte_incl,
    output logic              bcc_after,
    output logic              end_no_bcc
);

    logic first_q, lead_dle_q, bcc_on_q, transp_q, dle_prev_q;
    logic first_d, lead_dle_d, bcc_on_d, transp_d, dle_prev_d;
    logic is_syn, is_dle, is_stx, is_soh, is_eot, is_enq;

    assign is_syn = (din == ctl_code(C_SYN, ebcdic));
    assign is_dle = (din == ctl_code(C_DLE, ebcdic));
    assign is_stx = (din == ctl_code(C_STX, ebcdic));
    assign is_soh = (din == ctl_code(C_SOH, ebcdic));
    assign is_eot = (din == ctl_code(C_EOT, ebcdic));
    assign is_enq = (din == ctl_code(C_ENQ, ebcdic));

    always_comb begin
        first_d    = first_q;
        lead_dle_d = lead_dle_q;
        bcc_on_d   = bcc_on_q;
        transp_d   = transp_q;
        dle_prev_d = dle_prev_q;
        byte_incl  = 1'b0;
        if (first_q) begin
            first_d = 1'b0;
            if (is_soh || is_stx) begin
                bcc_on_d = 1'b1;
            end else if (is_dle) begin
                lead_dle_d = 1'b1;
            end
        end else if (lead_dle_q) begin
            lead_dle_d = 1'b0;
            if (is_stx) begin
                bcc_on_d = 1'b1;
                transp_d = 1'b1;
            end
        end else if (!bcc_on_q) begin
            byte_incl = 1'b0;
        end else if (!transp_q) begin
            byte_incl = !is_syn;
        end else if (dle_prev_q) begin
            dle_prev_d = 1'b0;
            byte_incl  = !is_syn;
        end else if (is_dle) begin
            dle_prev_d = 1'b1;
        end else begin
            byte_incl = 1'b1;
        end
    end

    assign bcc_after  = bcc_on_d;
    assign end_no_bcc = (is_eot || is_enq) && (!transp_q || dle_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q    <= 1'b1;
            lead_dle_q <= 1'b0;
            bcc_on_q   <= 1'b0;
            transp_q   <= 1'b0;
            dle_prev_q <= 1'b0;
        end else if (clr) begin
            first_q    <= 1'b1;
            lead_dle_q <= 1'b0;
            bcc_on_q   <= 1'b0;
            transp_q   <= 1'b0;
            dle_prev_q <= 1'b0;
        end else if (accept) begin
            first_q    <= first_d;
            lead_dle_q <= lead_dle_d;
            bcc_on_q   <= bcc_on_d;
            transp_q   <= transp_d;
            dle_prev_q <= dle_prev_d;
        end
    end

endmodule

// File: rtl/bsc_tx_framer.sv
`timescale 1ns/1ps
module bsc_tx_framer
    import bsc_pkg::*;
#(
    parameter int PAD_CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_idle_mark,
    input  logic [PAD_CNT_W-1:0] cfg_pad_count,
    input  logic                 cfg_pad_zero,
    input  logic                 cfg_ebcdic,
    input  logic                 cfg_lrc,
    input  logic                 fifo_valid,
    input  logic [7:0]           fifo_data,
    input  logic                 fifo_eof,
    output logic                 fifo_rd,
    input  logic                 abort_req,
    input  logic                 ser_ready,
    output logic [7:0]           tx_char,
    output logic                 tx_active
);

    localparam int CHAR_W = BSC_CHAR_W;
    localparam int CRC_W  = BSC_CRC_W;

    tx_state_e              state, state_nx;
    logic [PAD_CNT_W-1:0]   pad_cnt;

    logic [CHAR_W-1:0] syn_c, eot_c, pad_c;
    logic in_frame, abort_hit, frame_go, accept, pads_on, pad_last;
    logic byte_incl, bcc_after, end_no_bcc;
    logic [CRC_W-1:0]  crc_val;
    logic [CHAR_W-1:0] lrc_val;

    assign syn_c = ctl_code(C_SYN, cfg_ebcdic);
    assign eot_c = ctl_code(C_EOT, cfg_ebcdic);
    assign pad_c = cfg_pad_zero ? PAD_FLAT : PAD_TOGGLE;

    assign in_frame  = (state == ST_LEAD_PAD) || (state == ST_SYN_A) ||
                       (state == ST_SYN_B)    || (state == ST_DATA)  ||
                       (state == ST_BCC_LO)   || (state == ST_BCC_HI);
    assign abort_hit = abort_req && in_frame;
    assign frame_go  = (state == ST_IDLE) && ser_ready && fifo_valid;
    assign accept    = (state == ST_DATA) && ser_ready && fifo_valid && !abort_req;
    assign pads_on   = cfg_idle_mark && (cfg_pad_count != '0);
    assign pad_last  = (pad_cnt == cfg_pad_count - 1'b1);

    bsc_frame_tracker #(.CHAR_W(CHAR_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (frame_go),
        .accept     (accept),
        .din        (fifo_data),
        .ebcdic     (cfg_ebcdic),
        .byte_incl  (byte_incl),
        .bcc_after  (bcc_after),
        .end_no_bcc (end_no_bcc)
    );

    bsc_bcc_unit #(.CHAR_W(CHAR_W), .CRC_W(CRC_W)) u_bcc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_go),
        .en    (accept && byte_incl),
        .din   (fifo_data),
        .crc_q (crc_val),
        .lrc_q (lrc_val)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (frame_go)  state_nx = pads_on ? ST_LEAD_PAD : ST_SYN_A;
            ST_LEAD_PAD:  if (ser_ready && pad_last) state_nx = ST_SYN_A;
            ST_SYN_A:     if (ser_ready) state_nx = ST_SYN_B;
            ST_SYN_B:     if (ser_ready) state_nx = ST_DATA;
            ST_DATA: begin
                if (accept && fifo_eof) begin
                    if (end_no_bcc || !bcc_after) state_nx = ST_TRAIL_PAD;
                    else                          state_nx = ST_BCC_LO;
                end
            end
            ST_BCC_LO:    if (ser_ready) state_nx = cfg_lrc ? ST_TRAIL_PAD : ST_BCC_HI;
            ST_BCC_HI:    if (ser_ready) state_nx = ST_TRAIL_PAD;
            ST_ABORT_EOT: if (ser_ready) state_nx = ST_TRAIL_PAD;
            ST_TRAIL_PAD: if (ser_ready) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
        if (abort_hit) state_nx = ser_ready ? ST_TRAIL_PAD : ST_ABORT_EOT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pad_cnt <= '0;
        end else begin
            state <= state_nx;
            if (frame_go)
                pad_cnt <= '0;
            else if (state == ST_LEAD_PAD && ser_ready)
                pad_cnt <= pad_cnt + 1'b1;
        end
    end

    always_comb begin
        tx_char = MARK_CHAR;
        unique case (state)
            ST_IDLE:      tx_char = cfg_idle_mark ? MARK_CHAR : syn_c;
            ST_LEAD_PAD:  tx_char = pad_c;
            ST_SYN_A,
            ST_SYN_B:     tx_char = syn_c;
            ST_DATA:      tx_char = fifo_valid ? fifo_data : syn_c;
            ST_BCC_LO:    tx_char = cfg_lrc ? lrc_val : crc_val[CHAR_W-1:0];
            ST_BCC_HI:    tx_char = crc_val[CRC_W-1:CHAR_W];
            ST_ABORT_EOT: tx_char = eot_c;
            ST_TRAIL_PAD: tx_char = TRAIL_CHAR;
            default:      tx_char = MARK_CHAR;
        endcase
        if (abort_hit) tx_char = eot_c;
        fifo_rd   = accept;
        tx_active = (state != ST_IDLE);
    end

endmodule

// File: rtl/bsc_tx_framer_chk.sv
`timescale 1ns/1ps
module bsc_tx_framer_chk
    import bsc_pkg::*;
#(
    parameter int PAD_CNT_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_idle_mark,
    input logic [PAD_CNT_W-1:0] cfg_pad_count,
    input logic                 fifo_valid,
    input logic                 fifo_rd,
    input logic                 abort_req,
    input logic                 ser_ready,
    input tx_state_e            state,
    input logic [PAD_CNT_W-1:0] pad_cnt
);

    logic in_frame_c;
    assign in_frame_c = (state == ST_LEAD_PAD) || (state == ST_SYN_A) ||
                        (state == ST_SYN_B)    || (state == ST_DATA)  ||
                        (state == ST_BCC_LO)   || (state == ST_BCC_HI);

    p_rd_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (fifo_valid && ser_ready && !abort_req));

    p_rd_only_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DATA) |-> !fifo_rd);

    p_pad_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD_PAD) |-> (cfg_idle_mark && (pad_cnt < cfg_pad_count)));

    p_syn_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYN_A && ser_ready && !abort_req) |=> (state == ST_SYN_B));

    p_abort_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && in_frame_c && !ser_ready) |=> (state == ST_ABORT_EOT));

    p_abort_sent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && in_frame_c && ser_ready) |=> (state == ST_TRAIL_PAD));

    p_trail_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRAIL_PAD && ser_ready) |=> (state == ST_IDLE));

    p_hold_unready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_ready && !abort_req && state != ST_IDLE && state != ST_DATA)
            |=> $stable(state));

endmodule

bind bsc_tx_framer bsc_tx_framer_chk #(.PAD_CNT_W(PAD_CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_idle_mark (cfg_idle_mark),
    .cfg_pad_count (cfg_pad_count),
    .fifo_valid    (fifo_valid),
    .fifo_rd       (fifo_rd),
    .abort_req     (abort_req),
    .ser_ready     (ser_ready),
    .state         (state),
    .pad_cnt       (pad_cnt)
);

// File: tb/tb_bsc_tx_framer.sv
`timescale 1ns/1ps
module tb_bsc_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_idle_mark, cfg_pad_zero, cfg_ebcdic, cfg_lrc;
    logic [3:0] cfg_pad_count;
    logic       fifo_valid, fifo_eof, fifo_rd, abort_req, ser_ready, tx_active;
    logic [7:0] fifo_data, tx_char;

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0] frm[$];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];

    always #10 clk = ~clk;

    bsc_tx_framer #(.PAD_CNT_W(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_idle_mark(cfg_idle_mark), .cfg_pad_count(cfg_pad_count),
        .cfg_pad_zero(cfg_pad_zero), .cfg_ebcdic(cfg_ebcdic), .cfg_lrc(cfg_lrc),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_eof(fifo_eof),
        .fifo_rd(fifo_rd), .abort_req(abort_req), .ser_ready(ser_ready),
        .tx_char(tx_char), .tx_active(tx_active)
    );

    // R10 code values
    function automatic logic [7:0] k_syn(bit e); return e ? 8'h32 : 8'h16; endfunction
    function automatic logic [7:0] k_eot(bit e); return e ? 8'h37 : 8'h04; endfunction
    function automatic logic [7:0] k_enq(bit e); return e ? 8'h2D : 8'h05; endfunction
    function automatic logic [7:0] k_etb(bit e); return e ? 8'h26 : 8'h17; endfunction
    localparam logic [7:0] K_SOH = 8'h01, K_STX = 8'h02, K_ETX = 8'h03, K_DLE = 8'h10;

    function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Expected character stream for frm under the given settings (R2,R5-R8)
    function automatic void build_exp(bit mark, int pads, bit pz, bit e, bit lrc);
        bit first = 1, lead = 0, bon = 0, tr = 0, dp = 0, inc, term = 0;
        logic [15:0] crc = 0;
        logic [7:0]  lx = 0;
        exp_q.delete();
        if (mark) for (int i = 0; i < pads; i++) exp_q.push_back(pz ? 8'h00 : 8'hAA);
        exp_q.push_back(k_syn(e));
        exp_q.push_back(k_syn(e));
        foreach (frm[i]) begin
            logic [7:0] b = frm[i];
            exp_q.push_back(b);
            term = ((b == k_eot(e)) || (b == k_enq(e))) && (!tr || dp);
            inc = 0;
            if (first) begin
                first = 0;
                if (b == K_SOH || b == K_STX) bon = 1;
                else if (b == K_DLE) lead = 1;
            end else if (lead) begin
                lead = 0;
                if (b == K_STX) begin bon = 1; tr = 1; end
            end else if (!bon) begin
                inc = 0;
            end else if (!tr) begin
                inc = (b != k_syn(e));
            end else if (dp) begin
                dp = 0;
                inc = (b != k_syn(e));
            end else if (b == K_DLE) begin
                dp = 1;
            end else begin
                inc = 1;
            end
            if (inc) begin
                crc = crc_step(crc, b);
                lx  = lx ^ b;
            end
        end
        if (!term && bon) begin
            if (lrc) exp_q.push_back(lx);
            else begin
                exp_q.push_back(crc[7:0]);
                exp_q.push_back(crc[15:8]);
            end
        end
        exp_q.push_back(8'hFF);
    endfunction

    function automatic logic [7:0] rnd_byte(bit e);
        int s = $urandom_range(7);
        if (s == 0) return k_syn(e);
        if (s == 1) return K_DLE;
        return 8'($urandom_range(255));
    endfunction

    function automatic void gen_frame(int kind, bit e);
        int len = 1 + $urandom_range(9);
        frm.delete();
        case (kind)
            0: begin
                frm.push_back(K_STX);
                for (int i = 0; i < len; i++) frm.push_back(rnd_byte(e));
                frm.push_back($urandom_range(1) ? K_ETX : k_etb(e));
            end
            1: begin
                frm.push_back(K_SOH);
                for (int i = 0; i < 2; i++) frm.push_back(rnd_byte(e));
                frm.push_back(K_STX);
                for (int i = 0; i < len; i++) frm.push_back(rnd_byte(e));
                frm.push_back(K_ETX);
            end
            2: begin
                frm.push_back(K_DLE); frm.push_back(K_STX);
                for (int i = 0; i < len; i++) begin
                    logic [7:0] b = rnd_byte(e);
                    frm.push_back(b);
                    if (b == K_DLE) frm.push_back(K_DLE);
                    if ($urandom_range(5) == 0) begin
                        frm.push_back(K_DLE); frm.push_back(k_syn(e));
                    end
                end
                frm.push_back(K_DLE);
                frm.push_back($urandom_range(1) ? K_ETX : k_etb(e));
            end
            3: begin
                frm.push_back(K_STX);
                for (int i = 0; i < len; i++) frm.push_back(8'h41 + 8'(i));
                frm.push_back(k_enq(e));
            end
            4: frm.push_back($urandom_range(1) ? k_enq(e) : k_eot(e));
            default: begin
                frm.push_back(K_DLE); frm.push_back(8'h70);
            end
        endcase
    endfunction

    // abort_k: -1 none, -2 at first check byte, -3 random, >=0 that position
    task automatic run_frame(input bit mark, input int pads, input bit pz, input bit e,
                             input bit lrc, input int abort_k, input int gap_at,
                             input int gap_len, input string req);
        int  idx = 0, gapc = 0, guard = 0, k = abort_k, base;
        bit  aborted = 0, rd_bad = 0, gap;
        int  mism = -1;
        @(negedge clk);
        cfg_idle_mark = mark; cfg_pad_count = 4'(pads); cfg_pad_zero = pz;
        cfg_ebcdic = e; cfg_lrc = lrc;
        fifo_valid = 0; abort_req = 0; ser_ready = 0;
        build_exp(mark, pads, pz, e, lrc);
        base = (mark ? pads : 0) + 2;
        for (int i = 0; i < gap_len; i++) exp_q.insert(base + gap_at, k_syn(e));
        if (k == -2) k = exp_q.size() - 3;
        if (k == -3) k = $urandom_range(exp_q.size() - 2);
        if (k >= 0) begin
            while (exp_q.size() > k) void'(exp_q.pop_back());
            exp_q.push_back(k_eot(e));
            exp_q.push_back(8'hFF);
        end
        got_q.delete();
        while (got_q.size() < exp_q.size() && guard < 4000) begin
            @(negedge clk);
            guard++;
            gap = (gap_len > 0) && (idx == gap_at) && (gapc < gap_len) && tx_active;
            ser_ready  = gap ? 1'b1 : ($urandom_range(3) != 0);
            fifo_valid = !aborted && (idx < frm.size()) && !gap;
            fifo_data  = (idx < frm.size()) ? frm[idx] : 8'h00;
            fifo_eof   = (idx == frm.size() - 1);
            abort_req  = (k >= 0) && !aborted && tx_active && (got_q.size() == k);
            #1;
            if (gap) gapc++;
            if (fifo_rd) begin
                if (!ser_ready || !fifo_valid || abort_req || !tx_active ||
                    tx_char != fifo_data) rd_bad = 1;
                idx++;
            end
            if (ser_ready && tx_active) got_q.push_back(tx_char);
            if (abort_req) aborted = 1;
        end
        @(negedge clk);
        ser_ready = 0; fifo_valid = 0; abort_req = 0; fifo_eof = 0;
        #1;
        check(guard < 4000, req, "frame completed before guard", guard, 4000);
        foreach (exp_q[i])
            if (mism < 0 && (i >= got_q.size() || got_q[i] != exp_q[i])) mism = i;
        if (mism >= 0)
            check(0, req, $sformatf("char %0d of stream", mism),
                  (mism < got_q.size()) ? int'(got_q[mism]) : -1, exp_q[mism]);
        else
            check(1, req, "stream", 0, 0);
        check(!rd_bad, "R3", "fifo_rd qualification", rd_bad, 0);
        check(!tx_active && tx_char == (mark ? 8'hFF : k_syn(e)), "R8",
              "return to idle char", tx_char, mark ? 8'hFF : k_syn(e));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; cfg_idle_mark = 0; cfg_pad_count = 0; cfg_pad_zero = 0;
        cfg_ebcdic = 0; cfg_lrc = 0; fifo_valid = 0; fifo_data = 0; fifo_eof = 0;
        abort_req = 0; ser_ready = 0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state, SYN idle
        check(!tx_active && !fifo_rd && tx_char == 8'h16, "R1", "reset idle SYN", tx_char, 8'h16);
        rst_n = 1;
        @(negedge clk);
        cfg_idle_mark = 1; ser_ready = 1;
        #1;
        check(!tx_active && tx_char == 8'hFF, "R1", "mark idle", tx_char, 8'hFF);
        cfg_ebcdic = 1; cfg_idle_mark = 0;
        #1;
        check(tx_char == 8'h32, "R10", "EBCDIC SYN idle", tx_char, 8'h32);
        // R9 abort ignored while idle
        abort_req = 1;
        @(negedge clk);
        abort_req = 0;
        #1;
        check(!tx_active && tx_char == 8'h32, "R9", "abort in idle ignored", tx_active, 0);

        frm.delete(); frm = '{K_STX, 8'h41, 8'h16, 8'h42, K_ETX};
        run_frame(0, 5, 0, 0, 0, -1, 0, 0, "R5");            // SYN excluded, CRC, no pads in SYN idle
        frm = '{K_SOH, 8'h31, K_STX, 8'h41, 8'h42, 8'h26};
        run_frame(1, 3, 0, 1, 1, -1, 0, 0, "R7");            // EBCDIC, LRC, AA pads
        frm = '{K_DLE, K_STX, 8'h16, K_DLE, K_DLE, K_DLE, 8'h16, 8'h55, K_DLE, K_ETX};
        run_frame(1, 2, 1, 0, 0, -1, 0, 0, "R6");            // transparent, 00 pads
        frm = '{K_STX, 8'h41, 8'h42, 8'h05};
        run_frame(0, 0, 0, 0, 0, -1, 0, 0, "R8");            // ENQ end: no BCC
        frm = '{8'h37};
        run_frame(1, 1, 0, 1, 0, -1, 0, 0, "R8");            // lone EOT
        frm = '{K_DLE, 8'h70};
        run_frame(0, 0, 0, 0, 1, -1, 0, 0, "R8");            // unchecked control
        frm = '{K_STX, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45, K_ETX};
        run_frame(0, 0, 0, 0, 0, -1, 3, 4, "R4");            // underrun fill
        run_frame(1, 0, 0, 0, 0, -1, 0, 0, "R2");            // mark idle, zero pads
        run_frame(1, 4, 0, 0, 0, 6, 0, 0, "R9");             // abort in data
        run_frame(1, 4, 0, 0, 0, 1, 0, 0, "R9");             // abort in pads
        run_frame(0, 0, 0, 0, 0, 1, 0, 0, "R9");             // abort on second SYN
        run_frame(0, 0, 0, 1, 0, -2, 0, 0, "R9");            // abort on check byte

        for (int n = 0; n < 60; n++) begin
            int  kind = $urandom_range(5);
            bit  ee   = $urandom_range(1);
            int  ab   = ($urandom_range(5) == 0) ? -3 : -1;
            int  ga   = 0, gl = 0;
            gen_frame(kind, ee);
            if (ab == -1 && frm.size() > 2 && $urandom_range(3) == 0) begin
                ga = 1 + $urandom_range(frm.size() - 2);
                gl = 1 + $urandom_range(3);
            end
            run_frame($urandom_range(1), $urandom_range(15), $urandom_range(1), ee,
                      $urandom_range(1), ab, ga, gl,
                      (kind == 2) ? "R6" : (ab != -1) ? "R9" : (gl > 0) ? "R4" : "R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule